// File: doc/BRIEF.md
# SPI Burst Transfer Engine

This block is a register-mapped SPI master that moves one full-duplex burst through a small shared data buffer. Software writes the outgoing bytes into the buffer words, programs the burst length in bits (as the count minus one), picks whether chip select stays asserted once the burst ends, clears the completion flag and sets the start bit. The engine then clocks the bits out most-significant bit first in SPI mode 0. When input capture is enabled, it writes each bit sampled on MISO back into the buffer position that bit came from, so after the burst the buffer holds the received bytes.

The serial clock runs at the rate of an external enable strobe (`sclk_en`) from a divider. Each strobe advances the serial clock by one half period. The register port is a plain single-cycle 32-bit write port with a combinational read. A held chip select allows several bursts to form one longer SPI transaction. A software reset bit returns the engine to idle at any time without touching the buffer.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` and `spi_mosi` are 0, and the busy bit (bit 18 at 0x00) and the done flag (bit 4 at 0x30) both read 0.
- R2: A write with bit 18 set to the command register at 0x00 starts a burst. Bit 18 of that register reads 1 while the burst runs and 0 once it ends.
- R3: The length field at 0x20, bits [17 +: IDX_W], holds the number of bits minus one. A burst produces exactly that many plus one rising SCLK edges.
- R4: Transfer bit b is bit 7-(b mod 8) of buffer byte b/8. Byte k lives in the word at 0x40+4*(k/4), in lane k mod 4 (lane 0 = bits 7:0). MOSI is valid at each rising edge and does not change while SCLK is high.
- R5: With input capture on (bit 0 at 0x1C), the MISO value sampled at the rising edge of transfer bit b replaces that same buffer bit. With capture off, the buffer is unchanged.
- R6: With the data-out enable (bit 27 at 0x1C) clear, a start sets the done flag on the next clock. SCLK does not toggle and CS does not change.
- R7: The done flag (bit 4 at 0x30) is set when the last bit's falling SCLK edge is issued. It stays set until software writes the register with bit 4 clear.
- R8: Bit 30 at 0x2C, captured at start, decides the state of CS after the burst. When set, CS stays asserted. When clear, CS is released on the cycle that ends the burst.
- R9: When CS is released at start, it asserts first and the first rising SCLK edge follows two strobes later. When CS is already held, the first rising edge follows one strobe after the start.
- R10: While a burst runs, a new start and buffer-word writes are ignored. A length written during a burst does not change the burst in progress.
- R11: Writing bit 31 at 0x30 returns the engine to idle at once. It releases CS, drives SCLK low, clears busy and done, and leaves the buffer contents as they were.
- R12: SCLK changes level only on clocks where `sclk_en` is high, apart from a software reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 7 | Byte address of the register or buffer word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| sclk_en | input | 1 | Serial-clock half-period strobe from a divider |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The bench builds the engine with a 16-byte buffer, which makes the bit index 7 bits wide and the largest burst 128 bits. With that size, every legal burst length from 1 to 128 bits fits in one sweep, including partial final bytes and the full-buffer case, and each burst's transmitted bits and written-back buffer are compared against patterns computed arithmetically. Strobe spacing of one and three clocks covers back-to-back serial phases and gaps between strobes. The held-CS, lead-in, capture-off, busy-write and software-reset cases all run on the same small buffer.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 32;

    // word indices (byte address / 4)
    localparam logic [4:0] WI_CMD  = 5'd0;
    localparam logic [4:0] WI_CFG  = 5'd7;
    localparam logic [4:0] WI_LEN  = 5'd8;
    localparam logic [4:0] WI_CSC  = 5'd11;
    localparam logic [4:0] WI_STAT = 5'd12;
    localparam int         BUF_BASE_WI = 16;

    // bit positions software relies on
    localparam int B_START = 18;
    localparam int B_DIN   = 0;
    localparam int B_DOUT  = 27;
    localparam int B_LEN   = 17;
    localparam int B_HOLD  = 30;
    localparam int B_DONE  = 4;
    localparam int B_SRST  = 31;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_LEAD = 2'd1,
        ENG_LOW  = 2'd2,
        ENG_HIGH = 2'd3
    } eng_state_e;

endpackage

// File: rtl/spi_burst_shifter.sv
module spi_burst_shifter
    import spi_burst_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_i,
    input  logic             start_i,
    input  logic             dout_en_i,
    input  logic             din_en_i,
    input  logic             hold_cs_i,
    input  logic [IDX_W-1:0] nbits_m1_i,
    input  logic             sclk_en_i,
    input  logic             miso_i,
    input  logic             fetch_bit_i,
    output logic [IDX_W-1:0] fetch_idx_o,
    output logic             rx_we_o,
    output logic [IDX_W-1:0] rx_idx_o,
    output logic             rx_bit_o,
    output logic             busy_o,
    output logic             done_set_o,
    output logic             sclk_o,
    output logic             mosi_o,
    output logic             cs_n_o
);

    typedef struct packed {
        eng_state_e       state;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
        logic             hold;
        logic             din;
        logic             sclk;
        logic             mosi;
        logic             cs_n;
    } eng_regs_t;

    localparam eng_regs_t ENG_RST = '{
        state: ENG_IDLE,
        idx:   '0,
        last:  '0,
        hold:  1'b0,
        din:   1'b0,
        sclk:  1'b0,
        mosi:  1'b0,
        cs_n:  1'b1
    };

    eng_regs_t q, d;

    // lookahead: the bit that MOSI must present after the next transition
    assign fetch_idx_o = (q.state == ENG_HIGH) ? q.idx + IDX_W'(1) : '0;

    always_comb begin
        d          = q;
        rx_we_o    = 1'b0;
        done_set_o = 1'b0;
        unique case (q.state)
            ENG_IDLE: begin
                if (start_i) begin
                    if (!dout_en_i) begin
                        done_set_o = 1'b1;
                    end else begin
                        d.idx   = '0;
                        d.last  = nbits_m1_i;
                        d.hold  = hold_cs_i;
                        d.din   = din_en_i;
                        d.mosi  = fetch_bit_i;
                        d.cs_n  = 1'b0;
                        d.state = q.cs_n ? ENG_LEAD : ENG_LOW;
                    end
                end
            end
            ENG_LEAD: begin
                if (sclk_en_i) d.state = ENG_LOW;
            end
            ENG_LOW: begin
                if (sclk_en_i) begin
                    d.sclk  = 1'b1;
                    d.state = ENG_HIGH;
                    rx_we_o = q.din;
                end
            end
            ENG_HIGH: begin
                if (sclk_en_i) begin
                    d.sclk = 1'b0;
                    if (q.idx == q.last) begin
                        d.state    = ENG_IDLE;
                        d.mosi     = 1'b0;
                        d.cs_n     = ~q.hold;
                        done_set_o = 1'b1;
                    end else begin
                        d.idx   = q.idx + IDX_W'(1);
                        d.mosi  = fetch_bit_i;
                        d.state = ENG_LOW;
                    end
                end
            end
            default: d = ENG_RST;
        endcase
        if (soft_rst_i) begin
            d          = ENG_RST;
            rx_we_o    = 1'b0;
            done_set_o = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ENG_RST;
        else        q <= d;
    end

    assign rx_idx_o = q.idx;
    assign rx_bit_o = miso_i;
    assign busy_o   = (q.state != ENG_IDLE);
    assign sclk_o   = q.sclk;
    assign mosi_o   = q.mosi;
    assign cs_n_o   = q.cs_n;

    // R12: serial clock moves only on a strobe
    assert_sclk_on_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.sclk != $past(q.sclk)) && !$past(soft_rst_i)) |-> $past(sclk_en_i));

    // R4: data held while the clock is high
    assert_mosi_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sclk && $past(q.sclk)) |-> $stable(q.mosi));

    // R9: no clock edge without an asserted select
    assert_cs_during_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.sclk |-> !q.cs_n);

    // R10: a start while busy leaves the captured length alone
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !soft_rst_i) |=> $stable(q.last));

    // R5: capture coincides with the rising edge
    assert_rx_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we_o |=> q.sclk);

endmodule

// File: rtl/spi_burst_regs.sv
module spi_burst_regs
    import spi_burst_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    parameter int IDX_W     = $clog2(BUF_BYTES * 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              busy_i,
    input  logic              done_set_i,
    input  logic              rx_we_i,
    input  logic [IDX_W-1:0]  rx_idx_i,
    input  logic              rx_bit_i,
    input  logic [IDX_W-1:0]  fetch_idx_i,
    output logic              fetch_bit_o,
    output logic              start_o,
    output logic              soft_rst_o,
    output logic              dout_en_o,
    output logic              din_en_o,
    output logic              hold_cs_o,
    output logic [IDX_W-1:0]  nbits_m1_o,
    output logic              done_o
);

    localparam int BUF_BITS = BUF_BYTES * 8;
    localparam int WORDS    = BUF_BYTES / 4;

    typedef struct packed {
        logic [BUF_BITS-1:0] bits;
        logic                dout_en;
        logic                din_en;
        logic                hold;
        logic [IDX_W-1:0]    nbits_m1;
        logic                done;
    } reg_file_t;

    reg_file_t q, d;

    logic [4:0] wi;
    logic       unused_addr_lsbs;
    assign wi               = addr_i[ADDR_W-1:2];
    assign unused_addr_lsbs = ^addr_i[1:0];

    // transfer bit b sits at flat position b with the low three bits inverted
    assign fetch_bit_o = q.bits[fetch_idx_i ^ IDX_W'(7)];
    assign start_o     = wen_i && (wi == WI_CMD)  && wdata_i[B_START];
    assign soft_rst_o  = wen_i && (wi == WI_STAT) && wdata_i[B_SRST];

    always_comb begin
        d = q;
        if (wen_i) begin
            unique case (wi)
                WI_CFG: begin
                    d.dout_en = wdata_i[B_DOUT];
                    d.din_en  = wdata_i[B_DIN];
                end
                WI_LEN:  d.nbits_m1 = wdata_i[B_LEN +: IDX_W];
                WI_CSC:  d.hold     = wdata_i[B_HOLD];
                WI_STAT: d.done     = wdata_i[B_DONE];
                default: ;
            endcase
            if (!busy_i) begin
                for (int w = 0; w < WORDS; w++) begin
                    if (wi == 5'(BUF_BASE_WI + w)) d.bits[w*32 +: 32] = wdata_i;
                end
            end
        end
        if (rx_we_i) d.bits[rx_idx_i ^ IDX_W'(7)] = rx_bit_i;
        if (done_set_i) d.done = 1'b1;
        if (soft_rst_o) d.done = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (wi)
            WI_CMD:  rdata_o[B_START] = busy_i;
            WI_CFG: begin
                rdata_o[B_DOUT] = q.dout_en;
                rdata_o[B_DIN]  = q.din_en;
            end
            WI_LEN:  rdata_o[B_LEN +: IDX_W] = q.nbits_m1;
            WI_CSC:  rdata_o[B_HOLD] = q.hold;
            WI_STAT: rdata_o[B_DONE] = q.done;
            default: begin
                for (int w = 0; w < WORDS; w++) begin
                    if (wi == 5'(BUF_BASE_WI + w)) rdata_o = q.bits[w*32 +: 32];
                end
            end
        endcase
    end

    assign dout_en_o  = q.dout_en;
    assign din_en_o   = q.din_en;
    assign hold_cs_o  = q.hold;
    assign nbits_m1_o = q.nbits_m1;
    assign done_o     = q.done;

    // R10: while busy only the engine's own capture may change the buffer
    assert_buf_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !rx_we_i) |=> $stable(q.bits));

endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
    import spi_burst_pkg::*;
#(
    parameter int BUF_BYTES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wen,
    input  logic [6:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        sclk_en,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_cs_n
);

    localparam int IDX_W = $clog2(BUF_BYTES * 8);

    logic             busy, done_set, rx_we, rx_bit, fetch_bit;
    logic             start, soft_rst, dout_en, din_en, hold_cs, done;
    logic [IDX_W-1:0] rx_idx, fetch_idx, nbits_m1;

    spi_burst_regs #(
        .BUF_BYTES (BUF_BYTES),
        .IDX_W     (IDX_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wen_i       (reg_wen),
        .addr_i      (reg_addr),
        .wdata_i     (reg_wdata),
        .rdata_o     (reg_rdata),
        .busy_i      (busy),
        .done_set_i  (done_set),
        .rx_we_i     (rx_we),
        .rx_idx_i    (rx_idx),
        .rx_bit_i    (rx_bit),
        .fetch_idx_i (fetch_idx),
        .fetch_bit_o (fetch_bit),
        .start_o     (start),
        .soft_rst_o  (soft_rst),
        .dout_en_o   (dout_en),
        .din_en_o    (din_en),
        .hold_cs_o   (hold_cs),
        .nbits_m1_o  (nbits_m1),
        .done_o      (done)
    );

    spi_burst_shifter #(
        .IDX_W (IDX_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst_i  (soft_rst),
        .start_i     (start),
        .dout_en_i   (dout_en),
        .din_en_i    (din_en),
        .hold_cs_i   (hold_cs),
        .nbits_m1_i  (nbits_m1),
        .sclk_en_i   (sclk_en),
        .miso_i      (spi_miso),
        .fetch_bit_i (fetch_bit),
        .fetch_idx_o (fetch_idx),
        .rx_we_o     (rx_we),
        .rx_idx_o    (rx_idx),
        .rx_bit_o    (rx_bit),
        .busy_o      (busy),
        .done_set_o  (done_set),
        .sclk_o      (spi_sclk),
        .mosi_o      (spi_mosi),
        .cs_n_o      (spi_cs_n)
    );

    // R7: a burst that ends normally leaves the done flag set
    assert_done_on_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(soft_rst)) |-> done);

    // R8: an idle engine never drives the serial clock high
    assert_idle_sclk_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !spi_sclk);

endmodule

// File: tb/tb_spi_burst_engine.sv
module tb_spi_burst_engine;

    localparam int BYTES = 16;
    localparam int BITS  = BYTES * 8;
    localparam int WORDS = BYTES / 4;

    localparam logic [6:0] A_CMD = 7'h00, A_CFG = 7'h1C, A_LEN = 7'h20,
                           A_CSC = 7'h2C, A_STAT = 7'h30, A_BUF = 7'h40;

    logic        clk = 1'b0, rst_n = 1'b0, wen = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sclk_en = 1'b0, miso = 1'b0;
    logic        sclk, mosi, cs_n;

    always #4 clk = ~clk;

    spi_burst_engine #(.BUF_BYTES(BYTES)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wen(wen), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .sclk_en(sclk_en),
        .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
    );

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    // slave model and strobe generator, all at the falling clock edge
    int          div = 1, en_cnt = 0, viol = 0, rise_cnt = 0;
    logic        en_prev = 1'b0, sclk_prev = 1'b0, mon_clear = 1'b0;
    logic [BITS-1:0] mosi_log = '0;
    logic [BITS-1:0] rx_pat = '0;
    logic [7:0]  txb [BYTES];

    always @(negedge clk) begin
        if (rst_n && (sclk !== sclk_prev) && !en_prev) viol++;
        if (mon_clear) rise_cnt = 0;
        else if (sclk && !sclk_prev) begin
            if (rise_cnt < BITS) mosi_log[rise_cnt] = mosi;
            rise_cnt++;
        end
        miso = (rise_cnt < BITS) ? rx_pat[rise_cnt] : 1'b0;
        sclk_prev = sclk;
        if (en_cnt + 1 >= div) begin en_cnt = 0; sclk_en = 1'b1; end
        else begin en_cnt++; sclk_en = 1'b0; end
        en_prev = sclk_en;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] v);
        @(negedge clk); wen = 1'b1; addr = a; wdata = v;
        @(negedge clk); wen = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] v);
        @(negedge clk); addr = a; #1; v = rdata;
    endtask

    task automatic clear_mon();
        @(posedge clk); mon_clear = 1'b1;
        @(posedge clk); mon_clear = 1'b0;
    endtask

    task automatic load(input int seed);
        for (int k = 0; k < BYTES; k++) txb[k] = 8'(k * 37 + seed * 11 + 5);
        for (int b = 0; b < BITS; b++) rx_pat[b] = (((b * 5 + seed) % 7) < 3);
        for (int w = 0; w < WORDS; w++)
            wr(A_BUF + 7'(4 * w), {txb[4*w+3], txb[4*w+2], txb[4*w+1], txb[4*w]});
    endtask

    task automatic setup(input int nbits, input bit din, input bit hold);
        wr(A_LEN, 32'(nbits - 1) << 17);
        wr(A_CFG, (32'd1 << 27) | 32'(din));
        wr(A_CSC, 32'(hold) << 30);
        wr(A_STAT, 32'd0);
        clear_mon();
    endtask

    task automatic wait_done();
        logic [31:0] v;
        int n;
        n = 0;
        v = '0;
        while (!v[4] && n < 5000) begin rd(A_STAT, v); n++; end
        chk(v[4], "R7 done after burst", v, 32'h10);
    endtask

    function automatic logic [31:0] exp_word(input int w, input int nbits, input bit din);
        logic [31:0] e;
        e = '0;
        for (int by = 0; by < 4; by++)
            for (int j = 0; j < 8; j++) begin
                int k, b;
                k = 4 * w + by;
                b = 8 * k + 7 - j;
                e[by*8+j] = (din && b < nbits) ? rx_pat[b] : txb[k][j];
            end
        return e;
    endfunction

    task automatic verify(input int nbits, input bit din, input bit hold);
        logic [31:0] v;
        int bad;
        chk(rise_cnt == nbits, "R3 rising edge count", 32'(rise_cnt), 32'(nbits));
        bad = 0;
        for (int b = 0; b < nbits; b++)
            if (mosi_log[b] !== txb[b/8][7 - b%8]) bad++;
        chk(bad == 0, "R4 MOSI bit order mismatches", 32'(bad), 32'd0);
        for (int w = 0; w < WORDS; w++) begin
            rd(A_BUF + 7'(4 * w), v);
            chk(v == exp_word(w, nbits, din), "R5 buffer word after burst", v, exp_word(w, nbits, din));
        end
        chk(cs_n == !hold, "R8 CS after burst", 32'(cs_n), 32'(!hold));
        rd(A_CMD, v);
        chk(v[18] == 1'b0, "R2 busy cleared", v, 32'd0);
    endtask

    task automatic run(input int nbits, input bit din, input bit hold, input int seed);
        load(seed);
        setup(nbits, din, hold);
        wr(A_CMD, 32'd1 << 18);
        wait_done();
        verify(nbits, din, hold);
    endtask

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1, "R1 cs_n at reset", 32'(cs_n), 32'd1);
        chk(sclk == 1'b0, "R1 sclk at reset", 32'(sclk), 32'd0);
        chk(mosi == 1'b0, "R1 mosi at reset", 32'(mosi), 32'd0);
        rst_n = 1'b1;
        rd(A_CMD, v);  chk(v[18] == 1'b0, "R1 busy at reset", v, 32'd0);
        rd(A_STAT, v); chk(v[4] == 1'b0, "R1 done at reset", v, 32'd0);

        // R2 busy visible during a burst
        div = 3;
        load(1); setup(16, 1'b1, 1'b0);
        wr(A_CMD, 32'd1 << 18);
        rd(A_CMD, v); chk(v[18] == 1'b1, "R2 busy while running", v, 32'h40000);
        wait_done(); verify(16, 1'b1, 1'b0);

        // R3 R4 R5 sweep over every length, strobe every clock
        div = 1;
        for (int nb = 1; nb <= BITS; nb++) run(nb, 1'b1, 1'b0, nb);

        // R5 capture off, gapped strobes
        div = 3;
        run(8, 1'b0, 1'b0, 200);
        run(13, 1'b0, 1'b0, 201);
        run(BITS, 1'b0, 1'b0, 202);
        run(61, 1'b1, 1'b0, 203);

        // R9 lead-in and held CS, strobe every clock
        div = 1;
        load(300); setup(24, 1'b1, 1'b1);
        wr(A_CMD, 32'd1 << 18);
        n = 0;
        while (!sclk && n < 50) begin @(negedge clk); n++; end
        chk(n == 2, "R9 lead-in clocks with released CS", 32'(n), 32'd2);
        wait_done(); verify(24, 1'b1, 1'b1);
        repeat (5) @(negedge clk);
        chk(cs_n == 1'b0, "R8 CS stays held while idle", 32'(cs_n), 32'd0);
        load(301); setup(20, 1'b1, 1'b0);
        wr(A_CMD, 32'd1 << 18);
        n = 0;
        while (!sclk && n < 50) begin @(negedge clk); n++; end
        chk(n == 1, "R9 lead-in clocks with held CS", 32'(n), 32'd1);
        wait_done(); verify(20, 1'b1, 1'b0);

        // R7 sticky done and software clear
        rd(A_STAT, v); chk(v[4] == 1'b1, "R7 done stays set", v, 32'h10);
        wr(A_STAT, 32'd0);
        rd(A_STAT, v); chk(v[4] == 1'b0, "R7 done cleared by write", v, 32'd0);

        // R6 data-out disabled
        wr(A_CFG, 32'd0);
        clear_mon();
        wr(A_CMD, 32'd1 << 18);
        rd(A_STAT, v); chk(v[4] == 1'b1, "R6 done with data-out off", v, 32'h10);
        repeat (6) @(negedge clk);
        chk(rise_cnt == 0, "R6 no SCLK with data-out off", 32'(rise_cnt), 32'd0);
        chk(cs_n == 1'b1, "R6 CS unchanged with data-out off", 32'(cs_n), 32'd1);

        // R10 start, buffer and length writes during a burst
        div = 3;
        load(400); setup(BITS, 1'b1, 1'b0);
        wr(A_CMD, 32'd1 << 18);
        repeat (30) @(negedge clk);
        wr(A_CMD, 32'd1 << 18);
        wr(A_BUF, 32'hDEADBEEF);
        wr(A_LEN, 32'd3 << 17);
        wait_done();
        verify(BITS, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        chk(rise_cnt == BITS, "R10 restart while busy ignored", 32'(rise_cnt), 32'(BITS));

        // R12 no serial clock change without a strobe so far
        chk(viol == 0, "R12 SCLK moved without strobe", 32'(viol), 32'd0);

        // R11 software reset mid-burst
        load(500); setup(BITS, 1'b0, 1'b1);
        wr(A_CMD, 32'd1 << 18);
        repeat (40) @(negedge clk);
        wr(A_STAT, 32'd1 << 31);
        chk(cs_n == 1'b1, "R11 CS released by soft reset", 32'(cs_n), 32'd1);
        chk(sclk == 1'b0, "R11 SCLK low after soft reset", 32'(sclk), 32'd0);
        rd(A_CMD, v);  chk(v[18] == 1'b0, "R11 busy cleared", v, 32'd0);
        rd(A_STAT, v); chk(v[4] == 1'b0, "R11 done cleared", v, 32'd0);
        for (int w = 0; w < WORDS; w++) begin
            rd(A_BUF + 7'(4 * w), v);
            chk(v == exp_word(w, 0, 1'b0), "R11 buffer kept", v, exp_word(w, 0, 1'b0));
        end
        run(37, 1'b1, 1'b0, 501);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule